// File: doc/BRIEF.md
# Run-length wedgelet row decoder

This block expands compressed rows of a two-region binary block pattern into pattern bits. A pattern of side N (4, 8, 16 or 32) never changes value more than once along a row. Each stored row therefore needs only two fields: the value the row starts with, and the column at which the value switches. Rows live in a small synchronous pattern memory. A pattern occupies N consecutive words starting at a base address.

A request gives a pattern base, a side code, a row and a column. One cycle later the block returns two things: four consecutive pattern bits from the four-aligned group that holds the column, and the single bit at the exact column. Any position of any pattern can be fetched without expanding the rest of the pattern. The corner samples used for neighbour-based value prediction (row 0 column 0, row 0 column N-1, row N-1 column 0) are plain single-bit lookups through the same path. A fill port writes words into the memory. Building pattern tables is left to the agent that drives that port.

Top module: `wedge_row_expand`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rsp_valid` is 0.
- R2: A request accepted on one clock edge yields `rsp_valid` = 1 on the following edge. A cycle without a request yields `rsp_valid` = 0 on the following edge. Back-to-back requests each get their own response.
- R3: A memory word is 7 bits. Bit 6 holds the value at column 0. Bits 5:0 hold the change column.
- R4: The pattern bit at column c equals the start value XOR (c >= change column).
- R5: A change column equal to or greater than N leaves the whole row at its start value. A change column of 0 inverts the whole row.
- R6: `rsp_bits[i]` is the bit at column (c rounded down to a multiple of 4) + i. For N = 4 this is the whole row in one access.
- R7: `rsp_pt` is the bit at exactly column c.
- R8: The word read is at address base + (row mod N). The column is taken mod N.
- R9: Side code 0, 1, 2 and 3 selects N = 4, 8, 16 and 32.
- R10: Within one four-bit response the value changes at most once between neighbouring lanes.
- R11: A word written through the fill port is returned by later reads of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_en | input | 1 | Write one memory word |
| fill_addr | input | 6 | Write address |
| fill_data | input | 7 | Word written: {start value, change column} |
| req_valid | input | 1 | Lookup request |
| req_size | input | 2 | Side code (0:4, 1:8, 2:16, 3:32) |
| req_base | input | 6 | Address of the pattern's row 0 |
| req_row | input | 5 | Row within the pattern |
| req_col | input | 5 | Column within the row |
| rsp_valid | output | 1 | Response present |
| rsp_bits | output | 4 | Four aligned pattern bits, lane 0 = lowest column |
| rsp_pt | output | 1 | Pattern bit at the requested column |

## Verification
The hardest case to reach is a change column that lands inside a four-bit group away from lane 0. In that case the aligned span and the exact-column bit must agree, and the row must show exactly one transition at the right lane. This case appears only when the memory holds such a row for a larger side and the request's column sits in that group. The bench therefore fills rows whose change columns fall at 2, 3, 5, 9, 13 and 31. It then probes columns before, at and after each change. It also probes rows and columns beyond N to exercise the wrap, and no-change and change-at-zero rows to exercise the boundaries.

// File: rtl/wedge_pkg.sv
package wedge_pkg;

    localparam int SIDE_MIN  = 4;
    localparam int SIDE_MAX  = 32;
    localparam int LANES     = 4;
    localparam int POS_W     = $clog2(SIDE_MAX);
    localparam int CHG_W     = POS_W + 1;
    localparam int WORD_W    = CHG_W + 1;
    localparam int LANE_SH   = $clog2(LANES);

    typedef enum logic [1:0] {
        SIDE_4  = 2'd0,
        SIDE_8  = 2'd1,
        SIDE_16 = 2'd2,
        SIDE_32 = 2'd3
    } side_code_e;

    typedef struct packed {
        logic             start_val;
        logic [CHG_W-1:0] flip_col;
    } row_word_t;

    function automatic logic [CHG_W-1:0] side_of(side_code_e code);
        return CHG_W'(SIDE_MIN) << code;
    endfunction

    function automatic logic bit_at(row_word_t w, logic [POS_W-1:0] col);
        return w.start_val ^ ({1'b0, col} >= w.flip_col);
    endfunction

endpackage

// File: rtl/wedge_row_mem.sv
module wedge_row_mem
    import wedge_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  row_word_t         wr_word,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output row_word_t         rd_word
);

    row_word_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_word;
        end
        if (rd_en) begin
            rd_word <= store[rd_addr];
        end
    end

endmodule

// File: rtl/wedge_addr_gen.sv
module wedge_addr_gen
    import wedge_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  side_code_e        size,
    input  logic [ADDR_W-1:0] base,
    input  logic [POS_W-1:0]  row,
    input  logic [POS_W-1:0]  col,
    output logic [ADDR_W-1:0] addr,
    output logic [POS_W-1:0]  col_wrapped
);

    logic [CHG_W-1:0] side;
    logic [POS_W-1:0] mask;

    always_comb begin
        side        = side_of(size);
        mask        = POS_W'(side - CHG_W'(1));
        addr        = base + ADDR_W'(row & mask);
        col_wrapped = col & mask;
    end

endmodule

// File: rtl/wedge_lane_decode.sv
module wedge_lane_decode
    import wedge_pkg::*;
(
    input  row_word_t         word,
    input  logic [POS_W-1:0]  col,
    output logic [LANES-1:0]  bits,
    output logic              pt
);

    logic [POS_W-1:0] group_col;

    assign group_col = (col >> LANE_SH) << LANE_SH;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [POS_W-1:0] lane_col;
        assign lane_col = group_col + POS_W'(i);
        assign bits[i]  = bit_at(word, lane_col);
    end

    assign pt = bit_at(word, col);

endmodule

// File: rtl/wedge_row_expand.sv
module wedge_row_expand
    import wedge_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [WORD_W-1:0] fill_data,
    input  logic              req_valid,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [POS_W-1:0]  req_row,
    input  logic [POS_W-1:0]  req_col,
    output logic              rsp_valid,
    output logic [LANES-1:0]  rsp_bits,
    output logic              rsp_pt
);

    logic [ADDR_W-1:0] rd_addr;
    logic [POS_W-1:0]  col_now;
    logic [POS_W-1:0]  col_q;
    logic              valid_q;
    row_word_t         word_q;

    wedge_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .size        (side_code_e'(req_size)),
        .base        (req_base),
        .row         (req_row),
        .col         (req_col),
        .addr        (rd_addr),
        .col_wrapped (col_now)
    );

    wedge_row_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .wr_en   (fill_en),
        .wr_addr (fill_addr),
        .wr_word (row_word_t'(fill_data)),
        .rd_en   (req_valid),
        .rd_addr (rd_addr),
        .rd_word (word_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            col_q   <= '0;
        end else begin
            valid_q <= req_valid;
            if (req_valid) begin
                col_q <= col_now;
            end
        end
    end

    wedge_lane_decode u_dec (
        .word (word_q),
        .col  (col_q),
        .bits (rsp_bits),
        .pt   (rsp_pt)
    );

    assign rsp_valid = valid_q;

    logic [LANES-2:0] lane_diff;
    assign lane_diff = rsp_bits[LANES-1:1] ^ rsp_bits[LANES-2:0];

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !rsp_valid); // R1
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R2
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R2
    AST_PT_IN_SPAN: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_pt == rsp_bits[col_q[LANE_SH-1:0]]); // R7
    AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones(lane_diff) <= 1); // R10
    AST_ADDR_IN_PATTERN: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> CHG_W'(rd_addr - req_base) < side_of(side_code_e'(req_size))); // R8

endmodule

// File: tb/wedge_row_expand_test.sv
module wedge_row_expand_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fill_en = 1'b0;
    logic [5:0] fill_addr = '0;
    logic [6:0] fill_data = '0;
    logic       req_valid = 1'b0;
    logic [1:0] req_size = '0;
    logic [5:0] req_base = '0;
    logic [4:0] req_row = '0;
    logic [4:0] req_col = '0;
    logic       rsp_valid;
    logic [3:0] rsp_bits;
    logic       rsp_pt;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    wedge_row_expand uut (
        .clk(clk), .rst(rst),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
        .req_valid(req_valid), .req_size(req_size), .req_base(req_base),
        .req_row(req_row), .req_col(req_col),
        .rsp_valid(rsp_valid), .rsp_bits(rsp_bits), .rsp_pt(rsp_pt)
    );

    typedef struct packed {
        logic [1:0] sz;
        logic [5:0] base;
        logic [4:0] row;
        logic [4:0] col;
        logic [3:0] bits;
        logic       pt;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 6'd0,  5'd0,  5'd0,  4'b0011, 1'b1},
        '{2'd0, 6'd0,  5'd0,  5'd2,  4'b0011, 1'b0},
        '{2'd0, 6'd0,  5'd1,  5'd3,  4'b0000, 1'b0},
        '{2'd0, 6'd0,  5'd2,  5'd1,  4'b1111, 1'b1},
        '{2'd0, 6'd0,  5'd3,  5'd3,  4'b0111, 1'b0},
        '{2'd1, 6'd8,  5'd0,  5'd5,  4'b1110, 1'b1},
        '{2'd1, 6'd8,  5'd0,  5'd1,  4'b0000, 1'b0},
        '{2'd1, 6'd8,  5'd7,  5'd7,  4'b1111, 1'b1},
        '{2'd1, 6'd8,  5'd0,  5'd0,  4'b0000, 1'b0},
        '{2'd1, 6'd8,  5'd0,  5'd7,  4'b1110, 1'b1},
        '{2'd2, 6'd16, 5'd0,  5'd13, 4'b0001, 1'b0},
        '{2'd2, 6'd16, 5'd0,  5'd9,  4'b1111, 1'b1},
        '{2'd2, 6'd16, 5'd15, 5'd0,  4'b0000, 1'b0},
        '{2'd3, 6'd32, 5'd0,  5'd31, 4'b1000, 1'b1},
        '{2'd3, 6'd32, 5'd0,  5'd28, 4'b1000, 1'b0},
        '{2'd3, 6'd32, 5'd31, 5'd30, 4'b1111, 1'b1},
        '{2'd3, 6'd32, 5'd8,  5'd10, 4'b0001, 1'b0},
        '{2'd0, 6'd0,  5'd4,  5'd5,  4'b0011, 1'b1},
        '{2'd1, 6'd8,  5'd8,  5'd12, 4'b1110, 1'b0}
    };
    localparam string TAG [NV] = '{
        "R4 R6 R9", "R6 R7", "R5", "R5", "R3 R4", "R4 R9", "R6",
        "R5 R9", "R7", "R7 R10", "R4 R10", "R6 R9", "R5", "R9 R10",
        "R7", "R5", "R4 R6", "R8", "R8"
    };

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic put(input logic [5:0] a, input logic first, input logic [5:0] chg);
        @(negedge clk);
        fill_en   = 1'b1;
        fill_addr = a;
        fill_data = {first, chg};
    endtask

    task automatic ask(input vec_t v);
        req_valid = 1'b1;
        req_size  = v.sz;
        req_base  = v.base;
        req_row   = v.row;
        req_col   = v.col;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        for (int a = 0; a < 64; a++) put(6'(a), 1'b0, 6'd32);
        put(6'd0,  1'b1, 6'd2);
        put(6'd1,  1'b0, 6'd4);
        put(6'd2,  1'b0, 6'd0);
        put(6'd3,  1'b1, 6'd3);
        put(6'd8,  1'b0, 6'd5);
        put(6'd15, 1'b1, 6'd8);
        put(6'd16, 1'b1, 6'd13);
        put(6'd31, 1'b0, 6'd16);
        put(6'd32, 1'b0, 6'd31);
        put(6'd63, 1'b1, 6'd32);
        put(6'd40, 1'b1, 6'd9);
        @(negedge clk);
        fill_en = 1'b0;
        check("R1 reset", {4'b0, rsp_valid}, 5'd0);
        req_valid = 1'b1;
        @(negedge clk);
        check("R1 held", {4'b0, rsp_valid}, 5'd0);
        req_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1 after", {4'b0, rsp_valid}, 5'd0);

        for (int i = 0; i < NV; i++) begin
            ask(VEC[i]);
            @(negedge clk);
            req_valid = 1'b0;
            check({"R2 valid ", TAG[i]}, {4'b0, rsp_valid}, 5'd1);
            check(TAG[i], {rsp_bits, rsp_pt}, {VEC[i].bits, VEC[i].pt});
            @(negedge clk);
            check("R2 idle", {4'b0, rsp_valid}, 5'd0);
        end

        ask(VEC[0]);
        @(negedge clk);
        check("R2 b2b first", {rsp_bits, rsp_pt}, {VEC[0].bits, VEC[0].pt});
        ask(VEC[13]);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 b2b second", {rsp_bits, rsp_pt}, {VEC[13].bits, VEC[13].pt});

        put(6'd0, 1'b0, 6'd1);
        @(negedge clk);
        fill_en = 1'b0;
        ask(VEC[1]);
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 rewrite", {rsp_bits, rsp_pt}, {4'b1110, 1'b1});
        summary();
    end

endmodule